// File: doc/BRIEF.md
# Doorbell Interrupt Register Block

This block is the register slice of a shared-memory messaging device. Each node that shares a memory region has one copy of it. Software reaches it through a 32-bit word port into a 256-byte window. It holds an interrupt enable word and a pending word, and it drives one level interrupt from them. It reports the node's own identifier, and it turns doorbell writes into notifications aimed at a peer node.

The pending word can be loaded by software or by an event input that delivers one byte. Reading the pending word hands back its value and clears it in the same access. A doorbell write carries both the target node and the vector in one word. That target is checked against the live peer count and against the number of vectors that peer has registered. Only a doorbell that passes both checks leaves the block, as a single-cycle notification carrying both fields.

Top module: `dbell_regs`

## Requirements
- R1: After reset the enable word and the pending word read as zero, `irq_o` is low and `notify_valid_o` is low.
- R2: A write to offset 0x00 loads the enable word, and a read of 0x00 returns it unchanged. A write to offset 0x04 loads the pending word.
- R3: From the clock edge that changes either word, `irq_o` is high exactly when the bitwise AND of the pending word and the enable word is nonzero.
- R4: A read of offset 0x04 returns the pending word in the cycle `rd_en_i` is high. The word is zero after that clock edge, and `irq_o` follows it.
- R5: When `evt_valid_i` is high, the pending word becomes `evt_byte_i` zero-extended to 32 bits. This takes priority over a pending-word write and over the read-clear in the same cycle.
- R6: Before a write is decoded, its address bits 1:0 are dropped (the address is ANDed with 0xFC). Writes that land on 0x08 or on any offset outside 0x00, 0x04 and 0x0C change nothing.
- R7: A read of offset 0x08 returns `local_id_i` zero-extended when `mapped_i` is high, and 0xFFFFFFFF when it is low.
- R8: A read at any address other than exactly 0x00, 0x04 or 0x08 returns zero. This includes 0x0C and unaligned addresses.
- R9: A doorbell write (masked offset 0x0C) takes the destination from bits 31:16 and the vector from bits 7:0, and ignores bits 15:8. When the doorbell is valid, `notify_valid_o` is high for exactly the one cycle after the write edge, with those fields on `notify_dest_o` and `notify_vec_o`.
- R10: A doorbell is dropped when its destination is not below `peer_count_i`, or not below the table size NUM_PEERS.
- R11: A doorbell is dropped when its vector is not below the destination's vector count. Peer p's count is the 9-bit field at bits [9p+8:9p] of `vec_counts_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Byte offset inside the register window |
| wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, valid in the cycle `rd_en_i` is high |
| irq_o | output | 1 | Level interrupt |
| evt_valid_i | input | 1 | Incoming event strobe |
| evt_byte_i | input | 8 | Event value loaded into the pending word |
| mapped_i | input | 1 | Shared region is mapped |
| local_id_i | input | 16 | This node's identifier |
| peer_count_i | input | 4 | Live number of peers |
| vec_counts_i | input | 72 | Per-peer registered vector counts, 9 bits each |
| notify_valid_o | output | 1 | One-cycle notification pulse |
| notify_dest_o | output | 16 | Notification destination node |
| notify_vec_o | output | 8 | Notification vector |

## Verification
An incoming event can arrive in the same cycle as a read of the pending word, or in the same cycle as a software write to it. The bench provokes both by raising `evt_valid_i` in the very cycle that it strobes a read or a write of offset 0x04. It then judges the result in two steps. First, the read in that cycle must return the old value. Second, a follow-up read must return only the event byte, never zero and never the written data.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int DEST_W = 16;
  localparam int VEC_W  = 8;
  localparam int EVT_W  = 8;
  localparam int ID_W   = 16;
  localparam int VCNT_W = VEC_W + 1;

  localparam logic [ADDR_W-1:0] WR_ALIGN = 8'hFC;

  typedef enum logic [ADDR_W-1:0] {
    OFF_ENABLE  = 8'h00,
    OFF_PENDING = 8'h04,
    OFF_SELF_ID = 8'h08,
    OFF_RING    = 8'h0C
  } reg_off_e;
endpackage

// File: rtl/dbell_irq_unit.sv
module dbell_irq_unit
  import dbell_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_we_i,
  input  logic              pend_we_i,
  input  logic              pend_rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              evt_valid_i,
  input  logic [EVT_W-1:0]  evt_byte_i,
  output logic [DATA_W-1:0] enable_o,
  output logic [DATA_W-1:0] pending_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] enable_q, pending_q, pending_d;

  // event beats write, write beats read-clear
  always_comb begin
    pending_d = pending_q;
    if (evt_valid_i)    pending_d = {{(DATA_W-EVT_W){1'b0}}, evt_byte_i};
    else if (pend_we_i) pending_d = wdata_i;
    else if (pend_rd_i) pending_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q  <= '0;
      pending_q <= '0;
    end else begin
      if (en_we_i) enable_q <= wdata_i;
      pending_q <= pending_d;
    end
  end

  assign enable_o  = enable_q;
  assign pending_o = pending_q;
  assign irq_o     = |(pending_q & enable_q);

  // R5
  evt_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i |=> pending_q == {{(DATA_W-EVT_W){1'b0}}, $past(evt_byte_i)});

  // R4
  rd_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_rd_i && !pend_we_i && !evt_valid_i) |=> pending_q == '0);

  // R2
  enable_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_we_i |=> $stable(enable_q));

  // R3
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(en_we_i || pend_we_i || evt_valid_i));
endmodule

// File: rtl/dbell_ring_filter.sv
module dbell_ring_filter
  import dbell_pkg::*;
#(
  parameter int NUM_PEERS = 8,
  parameter int PCNT_W    = $clog2(NUM_PEERS + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        ring_we_i,
  input  logic [DEST_W-1:0]           dest_i,
  input  logic [VEC_W-1:0]            vec_i,
  input  logic [PCNT_W-1:0]           peer_count_i,
  input  logic [NUM_PEERS*VCNT_W-1:0] vec_counts_i,
  output logic                        notify_valid_o,
  output logic [DEST_W-1:0]           notify_dest_o,
  output logic [VEC_W-1:0]            notify_vec_o
);
  localparam int IDX_W = (NUM_PEERS > 1) ? $clog2(NUM_PEERS) : 1;
  localparam logic [DEST_W:0] TABLE_LIM = (DEST_W+1)'(NUM_PEERS);

  logic [VCNT_W-1:0] cnt_arr [NUM_PEERS];
  logic [IDX_W-1:0]  idx;
  logic              in_table, dest_ok, vec_ok, hit;
  logic [VCNT_W-1:0] sel_cnt;
  logic              valid_q;
  logic [DEST_W-1:0] dest_q;
  logic [VEC_W-1:0]  vec_q;

  for (genvar p = 0; p < NUM_PEERS; p++) begin : g_unpack
    assign cnt_arr[p] = vec_counts_i[p*VCNT_W +: VCNT_W];
  end

  assign idx      = dest_i[IDX_W-1:0];
  assign in_table = {1'b0, dest_i} < TABLE_LIM;
  assign sel_cnt  = in_table ? cnt_arr[idx] : '0;
  assign dest_ok  = in_table && (dest_i < DEST_W'(peer_count_i));
  assign vec_ok   = VCNT_W'(vec_i) < sel_cnt;
  assign hit      = ring_we_i && dest_ok && vec_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      dest_q  <= '0;
      vec_q   <= '0;
    end else begin
      valid_q <= hit;
      if (hit) begin
        dest_q <= dest_i;
        vec_q  <= vec_i;
      end
    end
  end

  assign notify_valid_o = valid_q;
  assign notify_dest_o  = dest_q;
  assign notify_vec_o   = vec_q;

  // R9
  pulse_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    notify_valid_o |-> $past(ring_we_i));

  // R10
  dest_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    notify_valid_o |-> notify_dest_o < DEST_W'($past(peer_count_i)));

  // R11
  vec_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    notify_valid_o |-> VCNT_W'(notify_vec_o) < $past(sel_cnt));
endmodule

// File: rtl/dbell_rd_mux.sv
module dbell_rd_mux
  import dbell_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] enable_i,
  input  logic [DATA_W-1:0] pending_i,
  input  logic              mapped_i,
  input  logic [ID_W-1:0]   local_id_i,
  output logic [DATA_W-1:0] rd_data_o
);
  always_comb begin
    unique case (addr_i)
      OFF_ENABLE:  rd_data_o = enable_i;
      OFF_PENDING: rd_data_o = pending_i;
      OFF_SELF_ID: rd_data_o = mapped_i ? {{(DATA_W-ID_W){1'b0}}, local_id_i} : '1;
      default:     rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/dbell_regs.sv
module dbell_regs
  import dbell_pkg::*;
#(
  parameter int NUM_PEERS = 8,
  localparam int PCNT_W   = $clog2(NUM_PEERS + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic                        rd_en_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [DATA_W-1:0]           rd_data_o,
  output logic                        irq_o,
  input  logic                        evt_valid_i,
  input  logic [EVT_W-1:0]            evt_byte_i,
  input  logic                        mapped_i,
  input  logic [ID_W-1:0]             local_id_i,
  input  logic [PCNT_W-1:0]           peer_count_i,
  input  logic [NUM_PEERS*VCNT_W-1:0] vec_counts_i,
  output logic                        notify_valid_o,
  output logic [DEST_W-1:0]           notify_dest_o,
  output logic [VEC_W-1:0]            notify_vec_o
);
  logic [ADDR_W-1:0] wr_off;
  logic              en_we, pend_we, pend_rd, ring_we;
  logic [DATA_W-1:0] enable_w, pending_w;

  assign wr_off  = addr_i & WR_ALIGN;
  assign en_we   = wr_en_i && (wr_off == OFF_ENABLE);
  assign pend_we = wr_en_i && (wr_off == OFF_PENDING);
  assign ring_we = wr_en_i && (wr_off == OFF_RING);
  assign pend_rd = rd_en_i && (addr_i == OFF_PENDING);

  dbell_irq_unit u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_we_i     (en_we),
    .pend_we_i   (pend_we),
    .pend_rd_i   (pend_rd),
    .wdata_i     (wdata_i),
    .evt_valid_i (evt_valid_i),
    .evt_byte_i  (evt_byte_i),
    .enable_o    (enable_w),
    .pending_o   (pending_w),
    .irq_o       (irq_o)
  );

  dbell_ring_filter #(.NUM_PEERS(NUM_PEERS), .PCNT_W(PCNT_W)) u_ring (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ring_we_i      (ring_we),
    .dest_i         (wdata_i[DATA_W-1 -: DEST_W]),
    .vec_i          (wdata_i[VEC_W-1:0]),
    .peer_count_i   (peer_count_i),
    .vec_counts_i   (vec_counts_i),
    .notify_valid_o (notify_valid_o),
    .notify_dest_o  (notify_dest_o),
    .notify_vec_o   (notify_vec_o)
  );

  dbell_rd_mux u_rd (
    .addr_i     (addr_i),
    .enable_i   (enable_w),
    .pending_i  (pending_w),
    .mapped_i   (mapped_i),
    .local_id_i (local_id_i),
    .rd_data_o  (rd_data_o)
  );

  // R6
  self_id_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_off == OFF_SELF_ID && !evt_valid_i && !rd_en_i)
      |=> $stable(pending_w) && $stable(enable_w));
endmodule

// File: tb/tb_dbell_regs.sv
`timescale 1ns/1ps
module tb_dbell_regs;
  localparam int NP = 8;
  localparam int VW = 9;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic        irq;
  logic        evt_valid = 1'b0;
  logic [7:0]  evt_byte = '0;
  logic        mapped = 1'b1;
  logic [15:0] local_id = 16'h0123;
  logic [3:0]  peer_count = 4'd3;
  logic [NP*VW-1:0] vec_counts;
  logic        n_valid;
  logic [15:0] n_dest;
  logic [7:0]  n_vec;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  dbell_regs #(.NUM_PEERS(NP)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rd_data_o(rd_data), .irq_o(irq),
    .evt_valid_i(evt_valid), .evt_byte_i(evt_byte), .mapped_i(mapped),
    .local_id_i(local_id), .peer_count_i(peer_count), .vec_counts_i(vec_counts),
    .notify_valid_o(n_valid), .notify_dest_o(n_dest), .notify_vec_o(n_vec)
  );

  // {rd?, addr, data, expected read, expected irq}
  localparam logic [73:0] TBL [18] = '{
    {1'b0, 8'h00, 32'h0000_00F0, 32'h0, 1'b0},        // R2 enable write
    {1'b1, 8'h00, 32'h0, 32'h0000_00F0, 1'b0},        // R2 enable readback
    {1'b0, 8'h04, 32'h0000_000F, 32'h0, 1'b0},        // R3 disjoint bits, no irq
    {1'b1, 8'h04, 32'h0, 32'h0000_000F, 1'b0},        // R4 read returns value
    {1'b1, 8'h04, 32'h0, 32'h0, 1'b0},                // R4 cleared
    {1'b0, 8'h04, 32'h0000_0030, 32'h0, 1'b1},        // R3 overlap raises irq
    {1'b0, 8'h00, 32'h0, 32'h0, 1'b0},                // R3 enable cleared drops irq
    {1'b0, 8'h00, 32'hFFFF_FFFF, 32'h0, 1'b1},        // R3
    {1'b1, 8'h08, 32'h0, 32'h0000_0123, 1'b1},        // R7 mapped id
    {1'b1, 8'h0C, 32'h0, 32'h0, 1'b1},                // R8 doorbell reads zero
    {1'b1, 8'h40, 32'h0, 32'h0, 1'b1},                // R8
    {1'b1, 8'h05, 32'h0, 32'h0, 1'b1},                // R8 unaligned read
    {1'b0, 8'h07, 32'h0000_0001, 32'h0, 1'b1},        // R6 0x07 -> pending
    {1'b1, 8'h04, 32'h0, 32'h0000_0001, 1'b0},        // R4 read-clear drops irq
    {1'b0, 8'h08, 32'h0000_DEAD, 32'h0, 1'b0},        // R6 id write ignored
    {1'b1, 8'h08, 32'h0, 32'h0000_0123, 1'b0},        // R6
    {1'b0, 8'h10, 32'h0, 32'h0, 1'b0},                // R6 unknown offset
    {1'b1, 8'h00, 32'h0, 32'hFFFF_FFFF, 1'b0}         // R6 enable unchanged
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic ring(input logic [7:0] a, input logic [15:0] dst, input logic [7:0] mid,
                      input logic [7:0] v, input logic exp, input string req);
    wr(a, {dst, mid, v});
    chk(req, {31'b0, n_valid}, {31'b0, exp});
    if (exp) begin
      chk(req, {16'b0, n_dest}, {16'b0, dst});
      chk(req, {24'b0, n_vec}, {24'b0, v});
    end
    @(negedge clk);
    chk("R9 single pulse", {31'b0, n_valid}, 32'b0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    vec_counts = '0;
    for (int p = 0; p < NP; p++)
      vec_counts[p*VW +: VW] = (p == 0) ? 9'd2 : (p == 1) ? 9'd4 : (p == 2) ? 9'd0 : 9'd8;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'b0);
    chk("R1 notify", {31'b0, n_valid}, 32'b0);
    rd(8'h00, r); chk("R1 enable", r, 32'h0);
    rd(8'h04, r); chk("R1 pending", r, 32'h0);

    for (int i = 0; i < 18; i++) begin
      logic [73:0] row;
      row = TBL[i];
      if (row[73]) begin
        rd(row[72:65], r);
        chk($sformatf("table row %0d read", i), r, row[32:1]);
      end else begin
        wr(row[72:65], row[64:33]);
      end
      chk($sformatf("table row %0d irq", i), {31'b0, irq}, {31'b0, row[0]});
    end

    // R7 unmapped id
    mapped = 1'b0;
    rd(8'h08, r); chk("R7 unmapped", r, 32'hFFFF_FFFF);
    mapped = 1'b1;

    // R5 event loads zero-extended byte
    evt_valid = 1'b1; evt_byte = 8'hA5;
    @(negedge clk);
    evt_valid = 1'b0;
    chk("R5 irq after event", {31'b0, irq}, 32'b1);
    rd(8'h04, r); chk("R5 event value", r, 32'h0000_00A5);

    // R5 event and read-clear in same cycle
    wr(8'h04, 32'h0000_0003);
    evt_valid = 1'b1; evt_byte = 8'h5A;
    rd(8'h04, r);
    evt_valid = 1'b0;
    chk("R5 read sees old", r, 32'h0000_0003);
    chk("R5 irq kept", {31'b0, irq}, 32'b1);
    rd(8'h04, r); chk("R5 event survives read-clear", r, 32'h0000_005A);

    // R5 event and write in same cycle
    evt_valid = 1'b1; evt_byte = 8'h11;
    wr(8'h04, 32'h0000_0077);
    evt_valid = 1'b0;
    rd(8'h04, r); chk("R5 event beats write", r, 32'h0000_0011);

    // doorbells: peer_count=3, counts {2,4,0,8...}
    ring(8'h0C, 16'd1, 8'hEE, 8'd3, 1'b1, "R9 valid doorbell");
    ring(8'h0C, 16'd0, 8'h00, 8'd1, 1'b1, "R9 last vector of peer 0");
    ring(8'h0E, 16'd0, 8'h00, 8'd0, 1'b1, "R6 doorbell via unaligned addr");
    ring(8'h0C, 16'd3, 8'h00, 8'd0, 1'b0, "R10 dest equals count");
    ring(8'h0C, 16'h0100, 8'h00, 8'd0, 1'b0, "R10 dest far out");
    ring(8'h0C, 16'd1, 8'h00, 8'd4, 1'b0, "R11 vector equals count");
    ring(8'h0C, 16'd2, 8'h00, 8'd0, 1'b0, "R11 peer with no vectors");
    peer_count = 4'd8;
    ring(8'h0C, 16'd7, 8'h00, 8'd7, 1'b1, "R10 count raised live");

    // R1 mid-run reset
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h04, 32'h0000_0001);
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1 irq under reset", {31'b0, irq}, 32'b0);
    rst_ni = 1'b1;
    @(negedge clk);
    rd(8'h00, r); chk("R1 enable after reset", r, 32'h0);
    rd(8'h04, r); chk("R1 pending after reset", r, 32'h0);

    finish_run();
  end
endmodule